// File: doc/BRIEF.md
# One-Shot Pulse Timer

This block produces a single timed pulse on one output pin. A free-running up-counter is cleared and restarted by a trigger. The output flip-flop turns active when the count reaches an "on" compare value and turns back to its idle level when the count reaches an "off" compare value. Software configures the block through a small write-only register port. The trigger is either a self-clearing bit in the output control register or a rising edge on an external input. That input is synchronised inside the block.

After the pulse the counter keeps running until the run mode is set to stop. A match interrupt pulse marks the end of each pulse and every later "off" match. The same flip-flop can instead run as a compare-toggle output when one-shot operation is disabled. A sticky flag records counter wrap-around. Software must keep the "on" value strictly below the "off" value.

Top module: `oneshot_timer`

## Requirements
- R1: After reset `pulseOut`, `matchIrq` and `ovfFlag` are 0, the run mode is stop and every control bit is 0.
- R2: Software trigger. Registers are selected by `wrAddr`: 0 run mode, 1 output control, 2 "on" compare, 3 "off" compare. Output control bits are: 0 output enable, 1 toggle on off-match, 2 toggle on on-match, 3 idle level, 4 one-shot enable, 5 trigger, 6 external-trigger enable. A write to address 1 with bits 4 and 5 set, while the run mode is not stop, restarts the counter from 0. Counting the write edge as edge 0, the output turns active after edge on+2 and returns to idle after edge off+2.
- R3: External trigger. With bits 4 and 6 set, a rising edge on `extTrig` starts the same pulse. The edge is taken through two synchroniser stages. Counting the first clock edge that samples `extTrig` high as edge 0, the output turns active after edge on+3 and idles after edge off+3.
- R4: `matchIrq` is high for exactly one cycle: the cycle after the counter equals the "off" compare value while running. In a one-shot pulse this coincides with the output returning to idle.
- R5: A trigger that arrives while a pulse is in progress is ignored. The pulse timing is unchanged, and the write does not reload the output flip-flop.
- R6: A trigger written in the same cycle that `matchIrq` rises is accepted and starts a new, complete pulse.
- R7: The trigger bit clears itself one cycle after the write, so a single write produces at most one pulse. A trigger written while stopped is not held for later.
- R8: Run mode 1 counts freely. Run modes 2 and 3 also clear the counter on an "off" match. In those modes `matchIrq` then repeats every off+1 cycles after the pulse, and the output does not pulse again.
- R9: Run mode 0 holds the counter at 0. It raises no interrupt and ignores triggers.
- R10: With output enable (bit 0) clear, `pulseOut` stays at the idle level (bit 3) whatever the flip-flop does.
- R11: A write to address 1 while no pulse is in progress loads the flip-flop with the idle level in bit 3. The active level of a pulse is the inverse of that level.
- R12: With one-shot (bit 4) clear, the flip-flop inverts on each on-match when bit 2 is set and on each off-match when bit 1 is set.
- R13: `ovfFlag` sets on the clock edge at which the running counter passes from all ones to zero. It stays set until the next write to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | CNT_W (16) | Register write data |
| extTrig | input | 1 | External trigger, asynchronous |
| pulseOut | output | 1 | Pulse output pin |
| matchIrq | output | 1 | Single-cycle "off" match interrupt |
| ovfFlag | output | 1 | Sticky counter wrap flag |

## Verification
A wrong counter value or a missed restart shows at the pin as an edge placed at the wrong cycle. It shows within one on/off window of the trigger, so the bench compares the pin and the interrupt cycle by cycle against windows computed from the compare values. A stuck busy state shows either as a retrigger that is wrongly accepted or as a legal retrigger that gets no second pulse, both within off+3 cycles. A stuck trigger bit shows as a second pulse that should not exist. A wrong wrap flag only shows after a full 2^16-cycle sweep.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_OCTL    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP_ON  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP_OFF = 2'd3;

  localparam int OC_OE      = 0;
  localparam int OC_TOG_OFF = 1;
  localparam int OC_TOG_ON  = 2;
  localparam int OC_INIT    = 3;
  localparam int OC_ONESHOT = 4;
  localparam int OC_TRIG    = 5;
  localparam int OC_EXT     = 6;

  typedef enum logic [1:0] {
    MODE_STOP    = 2'd0,
    MODE_FREE    = 2'd1,
    MODE_CLR     = 2'd2,
    MODE_CLR_ALT = 2'd3
  } runMode_t;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic ffWrite;
    logic ffVal;
    logic ffTog;
    logic ovfClr;
  } tmrStrobe_t;

endpackage

// File: rtl/oneshot_timer_ctrl.sv
module oneshot_timer_ctrl
  import oneshot_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  logic                extTrig,
  input  logic                eqOn,
  input  logic                eqOff,
  output tmrStrobe_t          strb,
  output logic [CNT_W-1:0]    cmpOn,
  output logic [CNT_W-1:0]    cmpOff,
  output logic                outEn,
  output logic                initLvl,
  output logic                running,
  output logic                oneShot,
  output logic                busy,
  output logic                trigReq
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  runMode_t               modeQ;
  logic                   togOffQ;
  logic                   togOnQ;
  logic                   extEnQ;
  logic                   swTrigQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrevQ;
  logic                   wrMode;
  logic                   wrOctl;
  logic                   clrOnOff;
  logic                   extEdge;
  logic                   fire;

  assign wrMode   = wrEn && (wrAddr == ADDR_MODE);
  assign wrOctl   = wrEn && (wrAddr == ADDR_OCTL);
  assign running  = (modeQ != MODE_STOP);
  assign clrOnOff = (modeQ == MODE_CLR) || (modeQ == MODE_CLR_ALT);
  assign extEdge  = syncQ[LAST_STAGE] && !extPrevQ;
  assign trigReq  = swTrigQ || (extEnQ && extEdge);
  assign fire     = trigReq && oneShot && running && !busy;

  // Register file and trigger bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_STOP;
      outEn   <= 1'b0;
      togOffQ <= 1'b0;
      togOnQ  <= 1'b0;
      initLvl <= 1'b0;
      oneShot <= 1'b0;
      extEnQ  <= 1'b0;
      swTrigQ <= 1'b0;
      cmpOn   <= '0;
      cmpOff  <= '0;
    end else begin
      if (wrMode) modeQ <= runMode_t'(wrData[1:0]);
      if (wrOctl) begin
        outEn   <= wrData[OC_OE];
        togOffQ <= wrData[OC_TOG_OFF];
        togOnQ  <= wrData[OC_TOG_ON];
        initLvl <= wrData[OC_INIT];
        oneShot <= wrData[OC_ONESHOT];
        extEnQ  <= wrData[OC_EXT];
      end
      if (wrEn && (wrAddr == ADDR_CMP_ON))  cmpOn  <= wrData;
      if (wrEn && (wrAddr == ADDR_CMP_OFF)) cmpOff <= wrData;
      swTrigQ <= wrOctl && wrData[OC_TRIG];
    end
  end

  // External trigger synchroniser with edge history
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extTrig};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extTrig;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrevQ <= 1'b0;
    else       extPrevQ <= syncQ[LAST_STAGE];
  end

  // Pulse-in-progress state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busy <= 1'b0;
    else if (!running)       busy <= 1'b0;
    else if (fire)           busy <= 1'b1;
    else if (busy && eqOff)  busy <= 1'b0;
  end

  // Strobes toward the datapath
  always_comb begin
    strb        = '0;
    strb.cntRun = running;
    strb.cntClr = !running || fire || (clrOnOff && eqOff);
    strb.ovfClr = wrMode;
    if (wrOctl && !busy) begin
      strb.ffWrite = 1'b1;
      strb.ffVal   = wrData[OC_INIT];
    end else if (oneShot && busy && running && eqOff) begin
      strb.ffWrite = 1'b1;
      strb.ffVal   = initLvl;
    end else if (oneShot && busy && running && eqOn) begin
      strb.ffWrite = 1'b1;
      strb.ffVal   = !initLvl;
    end
    strb.ffTog = !oneShot && running &&
                 ((togOnQ && eqOn) || (togOffQ && eqOff));
  end

endmodule

// File: rtl/oneshot_timer_dp.sv
module oneshot_timer_dp
  import oneshot_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] cmpOn,
  input  logic [CNT_W-1:0] cmpOff,
  input  logic             outEn,
  input  logic             initLvl,
  output logic [CNT_W-1:0] cnt,
  output logic             eqOn,
  output logic             eqOff,
  output logic             pulseOut,
  output logic             matchIrq,
  output logic             ovfFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic outFf;

  assign eqOn  = (cnt == cmpOn);
  assign eqOff = (cnt == cmpOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntRun) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            ovfFlag <= 1'b0;
    else if (strb.ovfClr)                                 ovfFlag <= 1'b0;
    else if (strb.cntRun && !strb.cntClr && cnt == CNT_MAX) ovfFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchIrq <= 1'b0;
    else       matchIrq <= strb.cntRun && eqOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outFf <= 1'b0;
    else if (strb.ffWrite) outFf <= strb.ffVal;
    else if (strb.ffTog)   outFf <= !outFf;
  end

  assign pulseOut = outEn ? outFf : initLvl;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             extTrig,
  output logic             pulseOut,
  output logic             matchIrq,
  output logic             ovfFlag
);

  tmrStrobe_t       strb;
  logic [CNT_W-1:0] cmpOn;
  logic [CNT_W-1:0] cmpOff;
  logic [CNT_W-1:0] cntVal;
  logic             outEn;
  logic             initLvl;
  logic             eqOn;
  logic             eqOff;
  logic             running;
  logic             oneShot;
  logic             busy;
  logic             trigReq;

  oneshot_timer_ctrl #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .extTrig(extTrig),
    .eqOn   (eqOn),
    .eqOff  (eqOff),
    .strb   (strb),
    .cmpOn  (cmpOn),
    .cmpOff (cmpOff),
    .outEn  (outEn),
    .initLvl(initLvl),
    .running(running),
    .oneShot(oneShot),
    .busy   (busy),
    .trigReq(trigReq)
  );

  oneshot_timer_dp #(
    .CNT_W(CNT_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmpOn   (cmpOn),
    .cmpOff  (cmpOff),
    .outEn   (outEn),
    .initLvl (initLvl),
    .cnt     (cntVal),
    .eqOn    (eqOn),
    .eqOff   (eqOff),
    .pulseOut(pulseOut),
    .matchIrq(matchIrq),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             running,
  input logic             oneShot,
  input logic             busy,
  input logic             trigReq,
  input logic             eqOff,
  input logic [CNT_W-1:0] cnt,
  input logic             matchIrq
);

  AST_STOP_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (cnt == '0)); // R9

  AST_TRIGGER_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (running && oneShot && trigReq && !busy) |=> (cnt == '0 && busy)); // R2

  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (running && busy && !eqOff) |=> busy); // R5

  AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (running && busy && eqOff) |=> (matchIrq && !busy)); // R4

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |=> !matchIrq); // R4

endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .running (running),
  .oneShot (oneShot),
  .busy    (busy),
  .trigReq (trigReq),
  .eqOff   (eqOff),
  .cnt     (cntVal),
  .matchIrq(matchIrq)
);

// File: tb/test_oneshot_timer.sv
`timescale 1ns/1ps
module test_oneshot_timer;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic             extTrig = 1'b0;
  logic             pulseOut;
  logic             matchIrq;
  logic             ovfFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  oneshot_timer #(.CNT_W(CNT_W)) i_oneshot_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTrig(extTrig), .pulseOut(pulseOut), .matchIrq(matchIrq), .ovfFlag(ovfFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = CNT_W'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  function automatic logic expPin(int k, int on, int off, int base, bit init, bit oe, int retrigAt);
    bit act = (k >= on + base) && (k <= off + base - 1);
    if (retrigAt >= off + base && k >= retrigAt + on + 2 && k <= retrigAt + off + 1) act = 1;
    return (oe && act) ? ~init : init;
  endfunction

  function automatic logic expIrq(int k, int off, int base, int mode, int retrigAt);
    if (k == off + base) return 1'b1;
    if (mode >= 2 && k > off + base && ((k - off - base) % (off + 1)) == 0) return 1'b1;
    if (retrigAt >= off + base && k == retrigAt + off + 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic runShot(input int on, input int off, input bit init, input bit oe,
                         input bit ext, input int mode, input int retrigAt, input string tag);
    int base = ext ? 3 : 2;
    int kEnd;
    int ctl;
    bit pinBad = 0;
    bit irqBad = 0;
    int pinAct = 0, pinExp = 0, irqAct = 0, irqExp = 0;
    logic ep, ei;
    ctl = (oe ? 1 : 0) | (init ? 8 : 0) | 16 | (ext ? 64 : 0);
    wr(0, 0); wr(2, on); wr(3, off);
    if (ext) begin
      wr(1, ctl); wr(0, mode);
      @(negedge clk); extTrig = 1'b1;
      @(posedge clk); #1;
    end else begin
      wr(0, mode); wr(1, ctl | 32);
    end
    kEnd = (retrigAt > 0) ? retrigAt + off + on + 8 : off + on + base + 8;
    for (int k = 1; k <= kEnd; k++) begin
      @(negedge clk);
      if (k == retrigAt) begin wrEn = 1'b1; wrAddr = 2'd1; wrData = CNT_W'(ctl | 32); end
      if (k == 4) extTrig = 1'b0;
      @(posedge clk); #1;
      wrEn = 1'b0;
      ep = expPin(k, on, off, base, init, oe, retrigAt);
      ei = expIrq(k, off, base, mode, retrigAt);
      if (pulseOut !== ep && !pinBad) begin pinBad = 1; pinAct = int'(pulseOut); pinExp = int'(ep);
        $display("  pin mismatch at edge %0d (on=%0d off=%0d)", k, on, off); end
      if (matchIrq !== ei && !irqBad) begin irqBad = 1; irqAct = int'(matchIrq); irqExp = int'(ei);
        $display("  irq mismatch at edge %0d (on=%0d off=%0d)", k, on, off); end
    end
    chk(!pinBad, {tag, " pin"}, pinAct, pinExp);
    chk(!irqBad, {tag, " irq R4"}, irqAct, irqExp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int on, off;
    bit init, oe, ext;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pulseOut == 1'b0, "R1 pulseOut", int'(pulseOut), 0);
    chk(matchIrq == 1'b0, "R1 matchIrq", int'(matchIrq), 0);
    chk(ovfFlag == 1'b0,  "R1 ovfFlag", int'(ovfFlag), 0);

    // Directed pulses: R2 software, R3 external, R11 inverted idle level
    runShot(0, 3, 1'b0, 1'b1, 1'b0, 1, 0, "R2 min");
    runShot(5, 20, 1'b1, 1'b1, 1'b0, 1, 0, "R2 R11 high idle");
    runShot(4, 12, 1'b0, 1'b1, 1'b1, 1, 0, "R3 ext");
    // R10 output disabled keeps idle level
    runShot(3, 8, 1'b1, 1'b0, 1'b0, 1, 0, "R10 oe off");
    // R5 retrigger mid-pulse ignored
    runShot(5, 30, 1'b0, 1'b1, 1'b0, 1, 10, "R5 ignored");
    // R6 retrigger in the interrupt cycle accepted, R7 single pulse per write
    runShot(2, 9, 1'b0, 1'b1, 1'b0, 1, 11, "R6 R7 retrigger");
    // R8 clear-on-off mode repeats interrupt without new pulse
    runShot(3, 9, 1'b0, 1'b1, 1'b0, 2, 0, "R8 clear mode");

    // Random trials (R2 R3 R10 R11 R7)
    for (int t = 0; t < 20; t++) begin
      on   = $urandom_range(0, 30);
      off  = on + 1 + $urandom_range(0, 30);
      if (off < 3) off = 3;
      init = 1'($urandom_range(0, 1));
      oe   = ($urandom_range(0, 3) != 0);
      ext  = 1'($urandom_range(0, 1));
      runShot(on, off, init, oe, ext, 1, 0, ext ? "R3 R11 random" : "R2 R7 R11 random");
    end

    // R9 stop mode ignores trigger, then R7 trigger not held
    begin
      bit bad9 = 0, bad7 = 0;
      wr(0, 0); wr(2, 2); wr(3, 5); wr(1, 1 | 16 | 32);
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); #1;
        if (pulseOut !== 1'b0 || matchIrq !== 1'b0) bad9 = 1;
      end
      chk(!bad9, "R9 stop ignores trigger", int'(bad9), 0);
      wr(0, 1);
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); #1;
        if (pulseOut !== 1'b0) bad7 = 1;
      end
      chk(!bad7, "R7 trigger not held", int'(bad7), 0);
    end

    // R12 toggle mode with clear-on-off, on=4 off=10, period 11
    begin
      bit bad = 0;
      logic ep;
      int m;
      wr(0, 0); wr(2, 4); wr(3, 10); wr(1, 1 | 2 | 4);
      wr(0, 2);
      for (int k = 1; k <= 50; k++) begin
        @(posedge clk); #1;
        m = k % 11;
        ep = (m >= 5 && m <= 10);
        if (pulseOut !== ep && !bad) begin
          bad = 1;
          $display("FAIL R12 toggle at edge %0d: actual %0d expected %0d", k, pulseOut, ep);
        end
      end
      nChecks++;
      if (bad) nFails++;
    end

    // R13 overflow flag
    wr(0, 0); wr(1, 0);
    wr(0, 1);
    repeat ((1 << CNT_W) - 1) @(posedge clk);
    #1 chk(ovfFlag == 1'b0, "R13 before wrap", int'(ovfFlag), 0);
    @(posedge clk); #1;
    chk(ovfFlag == 1'b1, "R13 at wrap", int'(ovfFlag), 1);
    repeat (5) @(posedge clk); #1;
    chk(ovfFlag == 1'b1, "R13 sticky", int'(ovfFlag), 1);
    wr(0, 1);
    chk(ovfFlag == 1'b0, "R13 cleared by mode write", int'(ovfFlag), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule